// File: doc/BRIEF.md
# SPI Engine Host Register and Interrupt Front End

This block is the host-facing register file for an SPI command execution engine. A simple single-cycle register bus reads and writes word-aligned locations. Those locations cover identification, a soft reset for the engine, a four-source interrupt controller, the last completed synchronisation token, the fill counters of the three engine FIFOs, and the data ports that push commands and transmit bytes and pop received bytes.

The interrupt controller raises pending bits from FIFO threshold conditions and from a sync strobe that the engine sends when it retires a sync instruction. Threshold bits are level-driven: clearing one while its condition still holds has no lasting effect, so software drains or refills the FIFO until the condition goes away. The sync bit is edge-driven and stays set until it is cleared. A single interrupt line is the OR of all pending bits that are also enabled.

The FIFO memories and the engine itself live outside. This block only sees their room and level counts and drives their push and pop strobes. It never overflows or underflows them.

Top module: `spi_host_regs`

## Requirements
- R1: A read of byte address 0x00 returns the identification word: bits [23:16] = 1 (major), bits [15:8] = VER_MINOR, bits [7:0] = VER_PATCH, bits [31:24] = 0.
- R2: The interrupt enable register at 0x80 holds wdata[3:0] and reads back. The source register at 0x88 reads pending AND enable. The `irq` output is high exactly when that AND is non-zero.
- R3: Pending bit 0 is set on every cycle in which cmd_room >= CMD_ROOM_THR. Bit 1 is set when tx_room >= TX_ROOM_THR. Bit 2 is set when rx_level >= RX_LVL_THR. A set condition wins over a clear in the same cycle, so a cleared bit reappears while its condition holds.
- R4: Writing 0x84 clears each pending bit whose wdata bit is 1 and leaves the others unchanged. Writing 0xFF clears all bits whose set condition is absent. The pending register reads at 0x84.
- R5: A one-cycle `sync_valid` pulse sets pending bit 3 and latches `sync_id_in`. A read of 0xC0 returns the latched 8-bit ID, which is 0 after reset.
- R6: Writing 0x40 stores wdata[0] and drives it on `engine_rst` (1 holds the engine in reset, 0 releases it). The register reads back at 0x40 and is 0 after reset.
- R7: Reads of 0xD0, 0xD4 and 0xD8 return cmd_room, tx_room and rx_level, zero-extended.
- R8: A write to 0xE0 pulses `cmd_push` in that cycle with `cmd_data` = wdata[15:0] only if cmd_room is non-zero. Otherwise the write is dropped.
- R9: A write to 0xE4 pulses `tx_push` with `tx_data` = wdata[7:0] only if tx_room is non-zero. Otherwise the write is dropped.
- R10: A read of 0xE8 returns the FIFO head `rx_data` and pulses `rx_pop` when rx_level is non-zero. When rx_level is zero it returns 0 and does not pop.
- R11: A read of 0xEC returns the head (0 when empty) and never pulses `rx_pop`.
- R12: `rdata` is registered. It takes the value of a read on the clock edge that samples `rd_en`, and holds it until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address, bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cmd_room | input | CNT_W | Free entries in command FIFO |
| cmd_push | output | 1 | Command FIFO push |
| cmd_data | output | 16 | Command word pushed |
| tx_room | input | CNT_W | Free entries in transmit FIFO |
| tx_push | output | 1 | Transmit FIFO push |
| tx_data | output | 8 | Transmit byte pushed |
| rx_level | input | CNT_W | Filled entries in receive FIFO |
| rx_data | input | 8 | Head of receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop |
| sync_valid | input | 1 | Engine retired a sync instruction |
| sync_id_in | input | 8 | ID of that sync instruction |
| engine_rst | output | 1 | Holds engine and FIFOs in reset |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 4, thresholds of 8 (command room), 6 (transmit room) and 3 (receive level), and version 1.2.0x61. With these 4-bit counters, random room and level values fall on both sides of every threshold and hit the exact boundary values. The empty and full cases (0) that drop pushes and suppress pops come up often. The small widths also let directed steps walk a counter across its threshold, so the bench can show a cleared bit coming back and then staying away.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int CNT_W        = 5,
  parameter int CMD_ROOM_THR = 16,
  parameter int TX_ROOM_THR  = 16,
  parameter int RX_LVL_THR   = 16,
  parameter int VER_MINOR    = 0,
  parameter int VER_PATCH    = 8'h61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [CNT_W-1:0] cmd_room,
  output logic             cmd_push,
  output logic [15:0]      cmd_data,
  input  logic [CNT_W-1:0] tx_room,
  output logic             tx_push,
  output logic [7:0]       tx_data,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [7:0]       rx_data,
  output logic             rx_pop,
  input  logic             sync_valid,
  input  logic [7:0]       sync_id_in,
  output logic             engine_rst,
  output logic             irq
);
  localparam logic [5:0] A_VER = 6'h00, A_RST = 6'h10, A_IEN = 6'h20, A_IPND = 6'h21,
                         A_ISRC = 6'h22, A_SYNC = 6'h30, A_CROOM = 6'h34, A_TROOM = 6'h35,
                         A_RLVL = 6'h36, A_CDAT = 6'h38, A_TDAT = 6'h39, A_RPOP = 6'h3A,
                         A_RPEEK = 6'h3B;
  localparam logic [CNT_W-1:0] CMD_T = CNT_W'(CMD_ROOM_THR);
  localparam logic [CNT_W-1:0] TX_T  = CNT_W'(TX_ROOM_THR);
  localparam logic [CNT_W-1:0] RX_T  = CNT_W'(RX_LVL_THR);
  localparam logic [31:0] VER_WORD = {8'h00, 8'h01, 8'(VER_MINOR), 8'(VER_PATCH)};
  localparam int PAD = 32 - CNT_W;

  logic [5:0] wa;
  logic [3:0] en_q, pend_q, pend_set, pend_clr;
  logic [7:0] sync_q;
  logic       rst_q;
  logic       rx_has;
  logic [31:0] rd_val;

  assign wa     = addr[7:2];
  assign rx_has = rx_level != '0;

  assign cmd_push = wr_en && wa == A_CDAT && cmd_room != '0;
  assign cmd_data = wdata[15:0];
  assign tx_push  = wr_en && wa == A_TDAT && tx_room != '0;
  assign tx_data  = wdata[7:0];
  assign rx_pop   = rd_en && wa == A_RPOP && rx_has;

  assign pend_set = {sync_valid, rx_level >= RX_T, tx_room >= TX_T, cmd_room >= CMD_T};
  assign pend_clr = (wr_en && wa == A_IPND) ? wdata[3:0] : 4'h0;
  assign irq        = |(pend_q & en_q);
  assign engine_rst = rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      sync_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      if (sync_valid) sync_q <= sync_id_in;
      if (wr_en && wa == A_IEN) en_q <= wdata[3:0];
      if (wr_en && wa == A_RST) rst_q <= wdata[0];
    end
  end

  always_comb begin
    case (wa)
      A_VER:   rd_val = VER_WORD;
      A_RST:   rd_val = {31'd0, rst_q};
      A_IEN:   rd_val = {28'd0, en_q};
      A_IPND:  rd_val = {28'd0, pend_q};
      A_ISRC:  rd_val = {28'd0, pend_q & en_q};
      A_SYNC:  rd_val = {24'd0, sync_q};
      A_CROOM: rd_val = {{PAD{1'b0}}, cmd_room};
      A_TROOM: rd_val = {{PAD{1'b0}}, tx_room};
      A_RLVL:  rd_val = {{PAD{1'b0}}, rx_level};
      A_RPOP, A_RPEEK: rd_val = rx_has ? {24'd0, rx_data} : 32'd0;
      default: rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  p_no_cmd_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> cmd_room != '0);
  p_no_tx_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_room != '0);
  p_no_rx_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_has);
  p_peek_no_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wa == A_RPEEK) |-> !rx_pop);
  p_sync_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> (sync_q == $past(sync_id_in) && pend_q[3]));
  p_sync_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[3] && !(wr_en && wa == A_IPND && wdata[3])) |=> pend_q[3]);
  p_cmd_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_room >= CMD_T) |=> pend_q[0]);
  p_irq_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q != '0);
endmodule

// File: tb/tb_spi_host_regs.sv
module tb_spi_host_regs;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [CW-1:0] cmd_room = 0, tx_room = 0, rx_level = 0;
  logic [7:0] rx_data = 0, sync_id_in = 0, tx_data;
  logic [15:0] cmd_data;
  logic cmd_push, tx_push, rx_pop, sync_valid = 0, engine_rst, irq;
  int nchk = 0, nfail = 0;
  logic w_cp, w_tp, r_pop;
  logic [15:0] w_cd;
  logic [7:0] w_td;

  always #5 clk = ~clk;

  spi_host_regs #(.CNT_W(CW), .CMD_ROOM_THR(8), .TX_ROOM_THR(6), .RX_LVL_THR(3),
                  .VER_MINOR(2), .VER_PATCH(8'h61)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    #1 w_cp = cmd_push; w_cd = cmd_data; w_tp = tx_push; w_td = tx_data;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    #1 r_pop = rx_pop;
    @(posedge clk); @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  task automatic pulse_sync(input logic [7:0] id);
    sync_valid = 1; sync_id_in = id;
    @(posedge clk); @(negedge clk);
    sync_valid = 0;
  endtask

  function automatic logic [3:0] thr_bits(input logic [CW-1:0] cr, tr, rl);
    return {1'b0, rl >= 4'd3, tr >= 4'd6, cr >= 4'd8};
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #1_900_000;
    nfail++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, prev;
    logic [3:0] en, ep;
    logic [7:0] id, rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(engine_rst == 0 && irq == 0, "R6 reset outputs", {engine_rst, irq}, 0);
    bus_read(8'h80, v); chk(v == 0, "R2 enable after reset", v, 0);
    bus_read(8'h84, v); chk(v == 0, "R4 pending after reset", v, 0);
    bus_read(8'hC0, v); chk(v == 0, "R5 sync id after reset", v, 0);
    bus_read(8'h00, v); chk(v == 32'h0001_0261, "R1 version", v, 32'h0001_0261);
    prev = v;
    rd_en = 1; addr = 8'h44; #1;
    chk(rdata == prev, "R12 rdata held before edge", rdata, prev);
    @(posedge clk); @(negedge clk); rd_en = 0;
    chk(rdata == 0, "R12 unmapped reads 0", rdata, 0);

    bus_write(8'h40, 1); chk(engine_rst == 1, "R6 reset asserted", engine_rst, 1);
    bus_read(8'h40, v); chk(v == 1, "R6 reset readback", v, 1);
    bus_write(8'h40, 0); chk(engine_rst == 0, "R6 reset released", engine_rst, 0);

    cmd_room = 4'd11; tx_room = 4'd5; rx_level = 4'd9;
    bus_read(8'hD0, v); chk(v == 11, "R7 cmd room", v, 11);
    bus_read(8'hD4, v); chk(v == 5, "R7 tx room", v, 5);
    bus_read(8'hD8, v); chk(v == 9, "R7 rx level", v, 9);

    cmd_room = 0; tx_room = 0; rx_level = 0;
    bus_write(8'hE0, 32'h1234); chk(w_cp == 0, "R8 full cmd drop", w_cp, 0);
    bus_write(8'hE4, 32'h77); chk(w_tp == 0, "R9 full tx drop", w_tp, 0);
    rx_data = 8'hA5;
    bus_read(8'hE8, v); chk(v == 0 && r_pop == 0, "R10 empty pop", {r_pop, v[30:0]}, 0);
    rx_level = 1;
    bus_read(8'hEC, v); chk(v == 8'hA5 && r_pop == 0, "R11 peek", {r_pop, v[30:0]}, 8'hA5);

    rx_level = 0;
    bus_write(8'h84, 32'hFF);
    bus_read(8'h84, v); chk(v == 0, "R4 clear all", v, 0);
    cmd_room = 4'd8; @(negedge clk);
    bus_write(8'h84, 32'h1);
    bus_read(8'h84, v); chk(v == 1, "R3 rearm at boundary", v, 1);
    cmd_room = 4'd7; @(negedge clk);
    bus_write(8'h84, 32'h1);
    bus_read(8'h84, v); chk(v == 0, "R3 below threshold stays clear", v, 0);

    pulse_sync(8'h5A);
    bus_read(8'hC0, v); chk(v == 8'h5A, "R5 sync id latched", v, 8'h5A);
    bus_read(8'h84, v); chk(v == 8, "R5 sync pending", v, 8);
    bus_write(8'h84, 32'h4);
    bus_read(8'h84, v); chk(v == 8, "R4 other bits untouched", v, 8);
    chk(irq == 0, "R2 irq masked", irq, 0);
    bus_write(8'h80, 32'h8);
    chk(irq == 1, "R2 irq enabled", irq, 1);
    bus_read(8'h88, v); chk(v == 8, "R2 source", v, 8);
    bus_write(8'h84, 32'h8);
    chk(irq == 0, "R4 sync cleared irq low", irq, 0);

    for (int k = 0; k < 250; k++) begin
      cmd_room = CW'($urandom); tx_room = CW'($urandom); rx_level = CW'($urandom);
      en = 4'($urandom);
      bus_write(8'h80, {28'd0, en});
      bus_write(8'h84, 32'hFF);
      ep = thr_bits(cmd_room, tx_room, rx_level);
      if (k % 5 == 0) begin
        id = 8'($urandom);
        pulse_sync(id);
        ep[3] = 1;
        bus_read(8'hC0, v); chk(v == {24'd0, id}, "R5 random sync id", v, {24'd0, id});
      end
      bus_read(8'h84, v); chk(v == {28'd0, ep}, "R3 random pending", v, {28'd0, ep});
      bus_read(8'h88, v); chk(v == {28'd0, ep & en}, "R2 random source", v, {28'd0, ep & en});
      chk(irq == |(ep & en), "R2 random irq", irq, |(ep & en));
      v = $urandom;
      bus_write(8'hE0, v);
      chk(w_cp == (cmd_room != 0) && w_cd == v[15:0], "R8 cmd push", {w_cp, w_cd}, {cmd_room != 0, v[15:0]});
      bus_write(8'hE4, v);
      chk(w_tp == (tx_room != 0) && w_td == v[7:0], "R9 tx push", {w_tp, w_td}, {tx_room != 0, v[7:0]});
      rd = 8'($urandom); rx_data = rd;
      bus_read(8'hE8, v);
      chk(v == (rx_level != 0 ? {24'd0, rd} : 0) && r_pop == (rx_level != 0), "R10 rx pop",
          {r_pop, v[30:0]}, {rx_level != 0, (rx_level != 0 ? {23'd0, rd} : 31'd0)});
      bus_read(8'hEC, v);
      chk(v == (rx_level != 0 ? {24'd0, rd} : 0) && r_pop == 0, "R11 rx peek",
          {r_pop, v[30:0]}, (rx_level != 0 ? {24'd0, rd} : 0));
    end
    summary();
    $finish;
  end
endmodule